// File: doc/BRIEF.md
# DMA Channel Transfer Interrupt Generator

This block follows the progress of a single DMA channel and produces a one-clock interrupt pulse for the CPU at points in the transfer that software chooses. A start command loads the channel configuration. A per-element completion strobe then advances the counters. Two layouts are supported. The first is a circular buffer that wraps around without end. The second is a block made of several frames of elements. An enable bit and a mode bit together choose whether the pulse fires at the half point and the full point of the buffer, or at frame ends and at the block end.

The block also gates transfer requests. A 4-bit select field picks one of 16 event inputs. A rising edge on the chosen input allows one element to move. Select code zero lets transfers run freely. Address generation, data movement and arbitration belong to the surrounding channel logic.

Top module: `dma_irq_gen`

## Requirements
- R1: While irq_en_i is 0, irq_o is never asserted, whatever the values of irq_mode_i and the layout.
- R2: In circular layout (circ_mode_i=1) with irq_en_i=1 and irq_mode_i=0, a pulse is issued only on the element that brings the position count to buf_len_i.
- R3: In circular layout with irq_en_i=1 and irq_mode_i=1, a pulse is issued on the element that brings the position to floor(buf_len_i/2), and another on the element that brings it to buf_len_i.
- R4: In multi-frame layout (circ_mode_i=0) with irq_en_i=1 and irq_mode_i=0, a single pulse is issued when the block completes. A block is frame_cnt_i+1 frames of elem_cnt_i elements each (elem_cnt_i of at least 1). At completion busy_o falls and done_o rises.
- R5: In multi-frame layout with irq_en_i=1 and irq_mode_i=1, a pulse is issued at the last element of every frame, including the final frame.
- R6: In circular layout the position returns to zero after the full point. The half and full pulses repeat on every pass, and busy_o stays high.
- R7: With sync_sel_i=0, req_o equals busy_o.
- R8: With sync_sel_i nonzero and not reserved, a rising edge on evt_i[sync_sel_i] while busy makes req_o high from the next cycle until an accepted xfer_done_i. Edges that arrive while req_o is already granted, or in the same cycle as that strobe, are dropped.
- R9: Select codes 8 to 12 are reserved: with them, req_o stays low.
- R10: irq_o is high for exactly the one cycle that follows the clock edge sampling the triggering xfer_done_i. When a frame end and the block end fall on the same element, only one pulse is issued.
- R11: A synchronous reset clears the counters and drives irq_o, req_o, busy_o and done_o low.
- R12: xfer_done_i has no effect while busy_o is low. start_i restarts the channel even when it is busy, clears done_o, and captures the layout, the counts and the buffer length. start_i takes priority over a coincident xfer_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load configuration and begin the transfer |
| xfer_done_i | input | 1 | One element has been moved |
| circ_mode_i | input | 1 | 1 = circular buffer, 0 = multi-frame block |
| irq_en_i | input | 1 | Interrupt enable |
| irq_mode_i | input | 1 | Selects the extra interrupt point (half buffer or frame end) |
| elem_cnt_i | input | CNT_W | Elements per frame |
| frame_cnt_i | input | FRM_W | Frames in the block minus one |
| buf_len_i | input | CNT_W | Circular buffer length in elements |
| sync_sel_i | input | SEL_W | Event select, 0 = unsynchronized |
| evt_i | input | 2**SEL_W | Synchronization event inputs |
| irq_o | output | 1 | One-cycle interrupt pulse |
| req_o | output | 1 | Transfer request gate |
| busy_o | output | 1 | Channel active |
| done_o | output | 1 | Block finished |

## Verification
The hardest case to reach is a frame end that coincides with the block end while the mode bit asks for frame interrupts. There, two pulses would be a plausible wrong answer. The stimulus reaches it with one-element frames and also with the last element of a multi-frame block. Dropping an event edge is just as delicate. The bench raises a second edge on the chosen input while a grant is still pending, and then raises one in the same cycle as the completion strobe. A reference model checks every cycle that neither edge leaves a grant behind.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  typedef enum logic {
    XM_MULTI = 1'b0,
    XM_CIRC  = 1'b1
  } xfer_mode_e;

  // Counter transitions seen on the current accepted element
  typedef struct packed {
    logic half;
    logic full;
    logic eof;
    logic eob;
  } xfer_evt_t;

endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int SEL_W = 4,
  parameter int NUM_EVT = 1 << SEL_W,
  parameter logic [NUM_EVT-1:0] RSVD_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic             xfer_done_i,
  input  logic [SEL_W-1:0] sync_sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic             req_o
);

  logic sel_evt;
  logic evt_d;
  logic grant_q;
  logic unsync;
  logic rise;
  logic sel_rsvd;

  assign unsync   = (sync_sel_i == '0);
  assign sel_rsvd = RSVD_MASK[sync_sel_i];

  always_comb begin
    if (unsync || sel_rsvd) sel_evt = 1'b0;
    else                    sel_evt = evt_i[sync_sel_i];
  end

  assign rise = sel_evt & ~evt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_d   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      evt_d <= sel_evt;
      if (!busy_i || xfer_done_i) grant_q <= 1'b0;
      else if (rise)              grant_q <= 1'b1;
    end
  end

  assign req_o = busy_i & (unsync | grant_q);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy_i |-> !req_o); // R7

  AST_RSVD_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_rsvd) && !$past(grant_q)) |-> !grant_q); // R9

endmodule

// File: rtl/dma_xfer_track.sv
module dma_xfer_track
  import dma_irq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             xfer_done_i,
  input  logic             circ_mode_i,
  input  logic [CNT_W-1:0] elem_cnt_i,
  input  logic [FRM_W-1:0] frame_cnt_i,
  input  logic [CNT_W-1:0] buf_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             circ_o,
  output xfer_evt_t        evt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  xfer_mode_e       mode_q;
  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] elem_q;
  logic [CNT_W-1:0] elem_ld_q;
  logic [FRM_W-1:0] frame_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_nx;
  logic             acc;
  logic             circ;

  assign circ   = (mode_q == XM_CIRC);
  assign acc    = busy_q & xfer_done_i & ~start_i;
  assign pos_nx = pos_q + ONE;

  always_comb begin
    evt_o      = '0;
    evt_o.full = acc & circ & (pos_nx == len_q);
    evt_o.half = acc & circ & (pos_nx == (len_q >> 1));
    evt_o.eof  = acc & ~circ & (elem_q == ONE);
    evt_o.eob  = acc & ~circ & (elem_q == ONE) & (frame_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= XM_MULTI;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      elem_q    <= '0;
      elem_ld_q <= '0;
      frame_q   <= '0;
      len_q     <= '0;
      pos_q     <= '0;
    end else if (start_i) begin
      mode_q    <= xfer_mode_e'(circ_mode_i);
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
      elem_q    <= elem_cnt_i;
      elem_ld_q <= elem_cnt_i;
      frame_q   <= frame_cnt_i;
      len_q     <= buf_len_i;
      pos_q     <= '0;
    end else if (acc) begin
      if (circ) begin
        pos_q <= evt_o.full ? '0 : pos_nx;
      end else if (evt_o.eob) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        elem_q <= '0;
      end else if (evt_o.eof) begin
        frame_q <= frame_q - 1'b1;
        elem_q  <= elem_ld_q;
      end else begin
        elem_q <= elem_q - ONE;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign circ_o = circ;

  AST_CIRC_STAYS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && circ) |=> busy_q); // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q)); // R4

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i) |=> (!busy_q && $stable(done_q))); // R12

endmodule

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      irq_en_i,
  input  logic      irq_mode_i,
  input  logic      circ_i,
  input  xfer_evt_t evt_i,
  output logic      irq_o
);

  logic hit;
  logic irq_q;

  always_comb begin
    if (circ_i) hit = evt_i.full | (irq_mode_i & evt_i.half);
    else        hit = evt_i.eob  | (irq_mode_i & evt_i.eof);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_en_i & hit;
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(irq_en_i)); // R1

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(evt_i.full) || $past(evt_i.half) || $past(evt_i.eof))); // R10

endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
  import dma_irq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FRM_W = 8,
  parameter int SEL_W = 4,
  parameter int NUM_EVT = 1 << SEL_W,
  parameter logic [NUM_EVT-1:0] RSVD_MASK = NUM_EVT'(16'h1F00)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               xfer_done_i,
  input  logic               circ_mode_i,
  input  logic               irq_en_i,
  input  logic               irq_mode_i,
  input  logic [CNT_W-1:0]   elem_cnt_i,
  input  logic [FRM_W-1:0]   frame_cnt_i,
  input  logic [CNT_W-1:0]   buf_len_i,
  input  logic [SEL_W-1:0]   sync_sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o,
  output logic               req_o,
  output logic               busy_o,
  output logic               done_o
);

  xfer_evt_t evt;
  logic      busy;
  logic      circ;

  dma_xfer_track #(.CNT_W(CNT_W), .FRM_W(FRM_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .xfer_done_i (xfer_done_i),
    .circ_mode_i (circ_mode_i),
    .elem_cnt_i  (elem_cnt_i),
    .frame_cnt_i (frame_cnt_i),
    .buf_len_i   (buf_len_i),
    .busy_o      (busy),
    .done_o      (done_o),
    .circ_o      (circ),
    .evt_o       (evt)
  );

  dma_irq_decode u_irq (
    .clk        (clk),
    .rst        (rst),
    .irq_en_i   (irq_en_i),
    .irq_mode_i (irq_mode_i),
    .circ_i     (circ),
    .evt_i      (evt),
    .irq_o      (irq_o)
  );

  dma_req_gate #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT), .RSVD_MASK(RSVD_MASK)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy),
    .xfer_done_i (xfer_done_i),
    .sync_sel_i  (sync_sel_i),
    .evt_i       (evt_i),
    .req_o       (req_o)
  );

  assign busy_o = busy;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !req_o && !busy_o && !done_o)); // R11

endmodule

// File: tb/tb_dma_irq_gen.sv
module tb_dma_irq_gen;
  localparam int CNT_W = 16;
  localparam int FRM_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, start_i = 1'b0, xfer_done_i = 1'b0;
  logic circ_mode_i = 1'b0, irq_en_i = 1'b0, irq_mode_i = 1'b0;
  logic [CNT_W-1:0] elem_cnt_i = '0, buf_len_i = '0;
  logic [FRM_W-1:0] frame_cnt_i = '0;
  logic [3:0] sync_sel_i = '0;
  logic [15:0] evt_i = '0;
  logic irq_o, req_o, busy_o, done_o;

  dma_irq_gen dut (.*);

  int checks = 0, fails = 0, cycles = 0, irq_cnt = 0;
  string cur_req = "R11";

  // behavioural reference state
  int m_busy = 0, m_done = 0, m_irq = 0, m_grant = 0, m_evd = 0;
  int m_elem = 0, m_frame = 0, m_pos = 0, l_circ = 0, l_elem = 0, l_len = 0;

  function automatic bit rsvd(int s);
    return (s >= 8) && (s <= 12);
  endfunction

  always @(posedge clk) begin
    int sel, sev, rise, irqn;
    if (rst) begin
      m_busy = 0; m_done = 0; m_irq = 0; m_grant = 0; m_evd = 0;
      m_elem = 0; m_frame = 0; m_pos = 0;
    end else begin
      sel  = int'(sync_sel_i);
      sev  = (sel == 0 || rsvd(sel)) ? 0 : int'(evt_i[sel]);
      rise = (sev == 1 && m_evd == 0) ? 1 : 0;
      m_evd = sev;
      irqn = 0;
      if (m_busy == 0 || xfer_done_i) m_grant = 0;
      else if (rise == 1) m_grant = 1;
      if (start_i) begin
        m_busy = 1; m_done = 0; l_circ = int'(circ_mode_i);
        l_elem = int'(elem_cnt_i); m_elem = l_elem;
        m_frame = int'(frame_cnt_i); l_len = int'(buf_len_i); m_pos = 0;
      end else if (m_busy == 1 && xfer_done_i) begin
        if (l_circ == 1) begin
          m_pos++;
          if (m_pos == l_len) begin irqn = int'(irq_en_i); m_pos = 0; end
          else if (m_pos == l_len / 2) irqn = int'(irq_en_i && irq_mode_i);
        end else if (m_elem == 1) begin
          if (m_frame == 0) begin m_busy = 0; m_done = 1; irqn = int'(irq_en_i); end
          else begin m_frame--; m_elem = l_elem; irqn = int'(irq_en_i && irq_mode_i); end
        end else m_elem--;
      end
      m_irq = irqn;
    end
  end

  always @(negedge clk) begin
    int m_req;
    if (!rst) begin
      m_req = (m_busy == 1 && (sync_sel_i == 0 || m_grant == 1)) ? 1 : 0;
      checks++;
      if (int'(irq_o) != m_irq || int'(req_o) != m_req ||
          int'(busy_o) != m_busy || int'(done_o) != m_done) begin
        fails++;
        $display("FAIL %s cycle %0d: irq/req/busy/done actual %0d%0d%0d%0d expected %0d%0d%0d%0d",
                 cur_req, cycles, irq_o, req_o, busy_o, done_o, m_irq, m_req, m_busy, m_done);
      end
      if (irq_o) irq_cnt++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic check_eq(string tag, int act, int exp);
    @(negedge clk);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic go(bit circ, bit en, bit md, int elem, int frm, int len, int sel);
    circ_mode_i = circ; irq_en_i = en; irq_mode_i = md;
    elem_cnt_i = CNT_W'(elem); frame_cnt_i = FRM_W'(frm); buf_len_i = CNT_W'(len);
    sync_sel_i = 4'(sel);
    start_i = 1'b1; step(); start_i = 1'b0;
    irq_cnt = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      xfer_done_i = 1'b1; step();
      xfer_done_i = 1'b0; step();
    end
    step();
  endtask

  initial begin
    step(); step(); step();
    check_eq("R11 reset busy", int'(busy_o), 0);
    rst = 1'b0; step();
    check_eq("R11 reset outputs", int'({irq_o, req_o, busy_o, done_o}), 0);

    cur_req = "R4";
    go(0, 1, 0, 3, 2, 0, 0); pulses(9);
    check_eq("R4 block irq count", irq_cnt, 1);
    check_eq("R4 done after block", int'(done_o), 1);

    cur_req = "R12"; irq_cnt = 0; pulses(3);
    check_eq("R12 idle strobes ignored", irq_cnt, 0);
    check_eq("R12 done held", int'(done_o), 1);

    cur_req = "R5";
    go(0, 1, 1, 3, 2, 0, 0); pulses(9);
    check_eq("R5 frame irq count", irq_cnt, 3);

    cur_req = "R1";
    go(0, 0, 1, 2, 1, 0, 0); pulses(4);
    check_eq("R1 disabled multi", irq_cnt, 0);
    go(1, 0, 1, 0, 0, 4, 0); pulses(8);
    check_eq("R1 disabled circ", irq_cnt, 0);

    cur_req = "R10";
    go(0, 1, 1, 1, 0, 0, 0); pulses(1);
    check_eq("R10 coincident single pulse", irq_cnt, 1);
    go(0, 1, 1, 1, 3, 0, 0);
    xfer_done_i = 1'b1; repeat (4) step(); xfer_done_i = 1'b0; step(); step();
    check_eq("R10 back-to-back frame pulses", irq_cnt, 4);

    cur_req = "R2";
    go(1, 1, 0, 0, 0, 6, 0); pulses(18);
    check_eq("R2 full-only count", irq_cnt, 3);
    check_eq("R6 still busy", int'(busy_o), 1);

    cur_req = "R3";
    go(1, 1, 1, 0, 0, 7, 0); pulses(14);
    check_eq("R3 half and full count", irq_cnt, 4);

    cur_req = "R12";
    go(0, 1, 0, 2, 0, 0, 0);
    start_i = 1'b1; xfer_done_i = 1'b1; step(); start_i = 1'b0; xfer_done_i = 1'b0; step();
    irq_cnt = 0; pulses(2);
    check_eq("R12 restart wins over strobe", irq_cnt, 1);

    cur_req = "R7";
    go(1, 1, 0, 0, 0, 4, 0);
    check_eq("R7 unsync request", int'(req_o), 1);

    cur_req = "R8";
    go(1, 1, 0, 0, 0, 4, 5); step();
    check_eq("R8 no request before event", int'(req_o), 0);
    evt_i[5] = 1'b1; step(); evt_i[5] = 1'b0; step();
    check_eq("R8 request after edge", int'(req_o), 1);
    evt_i[5] = 1'b1; step(); evt_i[5] = 1'b0; step();
    xfer_done_i = 1'b1; step(); xfer_done_i = 1'b0; step();
    check_eq("R8 extra edge not queued", int'(req_o), 0);
    evt_i[5] = 1'b1; step(); evt_i[5] = 1'b0; step();
    evt_i[5] = 1'b1; xfer_done_i = 1'b1; step(); evt_i[5] = 1'b0; xfer_done_i = 1'b0; step();
    check_eq("R8 edge with strobe dropped", int'(req_o), 0);
    evt_i[3] = 1'b1; step(); evt_i[3] = 1'b0; step();
    check_eq("R8 other input ignored", int'(req_o), 0);

    cur_req = "R9";
    go(1, 1, 0, 0, 0, 4, 9);
    evt_i = '1; step(); evt_i = '0; step(); evt_i = '1; step(); step();
    check_eq("R9 reserved code no request", int'(req_o), 0);
    evt_i = '0;

    rst = 1'b1; cur_req = "R11"; step(); step();
    check_eq("R11 reset mid-run busy", int'(busy_o), 0);
    rst = 1'b0; step();
    check_eq("R11 reset mid-run request", int'(req_o), 0);

    summary();
    $finish;
  end
endmodule